// File: doc/BRIEF.md
# SDRAM Bank State Tracker with Auto-Precharge Interruption

This block sits beside the command path of a four-bank SDRAM controller and keeps a cycle-accurate shadow of every bank's internal condition: idle, open, moving write data, moving read data, recovering after a write, or closing. It samples one command per clock from a registered command stream. The command carries an operation code, a bank index and an auto-precharge flag. From that stream the block derives, each cycle, which bank the write data beat belongs to and when read data is due on the bus. It also reports which banks can take a new command.

The central case is a write with auto-precharge that is cut short by a read or a write to another bank. The burst on the first bank stops in the very cycle the new command is taken. Its write recovery is counted from that cycle, not from where the burst would have ended. Its automatic close follows once recovery is over. The command stream has no back-pressure: a command is taken every cycle that `cmd_valid` is high. A command the banks cannot accept is not stalled. It is dropped from the state update and raises a sticky error flag.

Top module: `sdram_ap_tracker`

## Requirements
- R1: After reset every bank reads state 0 (idle), all `bank_ready` bits are 1, and `wr_accept`, `rd_valid` and `proto_err` are 0.
- R2: Operation codes are 0 no-op, 1 activate, 2 read, 3 write, 4 precharge. Activate to a bank in state 0 sets it to state 1 (open) in the next cycle. Each bank's 3-bit state sits at `bank_state[3*b +: 3]`.
- R3: A write taken in cycle T raises `wr_accept` with `wr_bank` equal to its bank in cycles T to T+BURST_LEN-1. The bank shows state 2 (write burst) from T+1 while beats remain.
- R4: An uninterrupted write with auto-precharge taken in cycle T shows state 4 (write recovery) from T+BURST_LEN for T_WR cycles. It then shows state 5 (closing) for T_RP cycles, then state 0.
- R5: A read or write taken in cycle T to another bank ends the running burst in cycle T. From cycle T on, no data beat is given to the old bank.
- R6: A write-with-auto-precharge bank interrupted in cycle T shows state 4 from T+1 until T+T_WR-1. It shows state 5 from T+T_WR for T_RP cycles, then state 0.
- R7: A read taken in cycle T to bank b raises `rd_valid` with `rd_bank`=b in cycles T+CAS_LAT to T+CAS_LAT+BURST_LEN-1. Beats whose issue cycle falls on or after an interrupting command's cycle are dropped.
- R8: A read burst shows state 3. A read with auto-precharge shows state 5 from T+BURST_LEN for T_RP cycles, then state 0. A read or write without auto-precharge returns the bank to state 1 at T+BURST_LEN.
- R9: `bank_ready[b]` is 1 exactly when bank b is in state 0 or 1.
- R10: A command with `cmd_valid` high is illegal in any of these cases: activate to a bank not in state 0; read or write to a bank not in state 1; precharge to a bank that is not ready; or codes 5 to 7. An illegal command sets `proto_err` from the next cycle on until reset, and changes no state and no strobe.
- R11: Precharge to an open bank shows state 5 for T_RP cycles from the next cycle, then state 0. Precharge to an idle bank leaves it idle.
- R12: An interrupted read burst goes to state 1 in the next cycle if it was taken without auto-precharge, or to state 5 (for T_RP cycles) if it was taken with auto-precharge. At most one bank is in state 2 or 3 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle (low acts as a no-op) |
| cmd_code | input | 3 | Operation code |
| cmd_bank | input | 2 | Target bank index |
| cmd_ap | input | 1 | Auto-precharge flag for read and write |
| bank_state | output | 12 | Three-bit state per bank |
| bank_ready | output | 4 | Bank can take a new command |
| wr_accept | output | 1 | Write data beat taken this cycle |
| wr_bank | output | 2 | Bank of the write beat |
| rd_valid | output | 1 | Read data beat due on the bus this cycle |
| rd_bank | output | 2 | Bank of the read beat |
| proto_err | output | 1 | Sticky illegal-command flag |

## Verification
`wr_accept` and `wr_bank` respond in the same cycle as the command, since write data travels with it. Bank states and `proto_err` change one cycle after the command. Read beats are due CAS_LAT cycles after each beat's issue cycle. Recovery and closing phases end T_WR and T_RP cycles after the cycle in which they start. The bench drives each command just after a falling edge and samples every output one time unit later. Its reference model advances absolute-time deadlines and a queue of due read beats, so each comparison lands in the cycle the requirement names.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [2:0] {
    BK_IDLE   = 3'd0,
    BK_ACTIVE = 3'd1,
    BK_WBURST = 3'd2,
    BK_RBURST = 3'd3,
    BK_WREC   = 3'd4,
    BK_PRE    = 3'd5
  } bank_st_e;

  localparam logic [2:0] OP_NOP   = 3'd0;
  localparam logic [2:0] OP_ACT   = 3'd1;
  localparam logic [2:0] OP_READ  = 3'd2;
  localparam logic [2:0] OP_WRITE = 3'd3;
  localparam logic [2:0] OP_PRE   = 3'd4;

endpackage

// File: rtl/sdram_cmd_check.sv
module sdram_cmd_check
  import sdram_trk_pkg::*;
#(
  parameter int NB = 4,
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_code,
  input  logic [BW-1:0] cmd_bank,
  input  bank_st_e      bank_st [NB],
  output logic [NB-1:0] hit,
  output logic          rd_now,
  output logic          wr_now,
  output logic          proto_err
);

  bank_st_e tgt;
  logic     in_range;
  logic     legal;
  logic     take;
  logic     bad;

  // legality of the incoming command against the target bank's state
  always_comb begin
    tgt      = BK_IDLE;
    in_range = 1'b0;
    for (int i = 0; i < NB; i++) begin
      if (cmd_bank == BW'(i)) begin
        tgt      = bank_st[i];
        in_range = 1'b1;
      end
    end
    case (cmd_code)
      OP_NOP:             legal = 1'b1;
      OP_ACT:             legal = (tgt == BK_IDLE);
      OP_READ, OP_WRITE:  legal = (tgt == BK_ACTIVE);
      OP_PRE:             legal = (tgt == BK_IDLE) || (tgt == BK_ACTIVE);
      default:            legal = 1'b0;
    endcase
    if (!in_range && (cmd_code != OP_NOP)) legal = 1'b0;
    bad  = cmd_valid && !legal;
    take = cmd_valid && legal && (cmd_code != OP_NOP);
  end

  for (genvar g = 0; g < NB; g++) begin : g_hit
    assign hit[g] = take && (cmd_bank == BW'(g));
  end

  assign rd_now = take && (cmd_code == OP_READ);
  assign wr_now = take && (cmd_code == OP_WRITE);

  always_ff @(posedge clk) begin
    if (!rst_n)   proto_err <= 1'b0;
    else if (bad) proto_err <= 1'b1;
  end

  // R10: the error flag never clears on its own
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

  // R10: an illegal command reaches no bank
  p_bad_no_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code > OP_PRE) |-> (hit == '0));

endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
  import sdram_trk_pkg::*;
#(
  parameter int BL  = 4,
  parameter int TWR = 2,
  parameter int TRP = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit,
  input  logic [2:0] op,
  input  logic       ap,
  input  logic       intr,
  output bank_st_e   st
);

  localparam int MX = (BL > TWR) ? ((BL > TRP) ? BL : TRP) : ((TWR > TRP) ? TWR : TRP);
  localparam int CW = $clog2(MX + 1);

  bank_st_e        st_n;
  logic [CW-1:0]   cnt, cnt_n;
  logic            apf, apf_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= BK_IDLE;
      cnt <= '0;
      apf <= 1'b0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
      apf <= apf_n;
    end
  end

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    apf_n = apf;
    case (st)
      BK_IDLE: begin
        if (hit && op == OP_ACT) st_n = BK_ACTIVE;
      end
      BK_ACTIVE: begin
        if (hit && op == OP_PRE) begin
          st_n  = BK_PRE;
          cnt_n = CW'(TRP);
        end else if (hit && op == OP_WRITE) begin
          apf_n = ap;
          if (BL > 1) begin
            st_n  = BK_WBURST;
            cnt_n = CW'(BL - 1);
          end else if (ap) begin
            st_n  = BK_WREC;
            cnt_n = CW'(TWR);
          end
        end else if (hit && op == OP_READ) begin
          apf_n = ap;
          if (BL > 1) begin
            st_n  = BK_RBURST;
            cnt_n = CW'(BL - 1);
          end else if (ap) begin
            st_n  = BK_PRE;
            cnt_n = CW'(TRP);
          end
        end
      end
      BK_WBURST: begin
        if (intr) begin
          // recovery counted from the interrupting cycle itself
          if (!apf) begin
            st_n = BK_ACTIVE;
          end else if (TWR > 1) begin
            st_n  = BK_WREC;
            cnt_n = CW'(TWR - 1);
          end else begin
            st_n  = BK_PRE;
            cnt_n = CW'(TRP);
          end
        end else if (cnt == CW'(1)) begin
          if (apf) begin
            st_n  = BK_WREC;
            cnt_n = CW'(TWR);
          end else begin
            st_n = BK_ACTIVE;
          end
        end else begin
          cnt_n = cnt - CW'(1);
        end
      end
      BK_RBURST: begin
        if (intr || cnt == CW'(1)) begin
          if (apf) begin
            st_n  = BK_PRE;
            cnt_n = CW'(TRP);
          end else begin
            st_n = BK_ACTIVE;
          end
        end else begin
          cnt_n = cnt - CW'(1);
        end
      end
      BK_WREC: begin
        if (cnt == CW'(1)) begin
          st_n  = BK_PRE;
          cnt_n = CW'(TRP);
        end else begin
          cnt_n = cnt - CW'(1);
        end
      end
      BK_PRE: begin
        if (cnt == CW'(1)) st_n = BK_IDLE;
        else               cnt_n = cnt - CW'(1);
      end
      default: st_n = BK_IDLE;
    endcase
  end

  // R4: write recovery only ever hands over to the closing phase
  p_rec_to_pre_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BK_WREC) |=> (st inside {BK_WREC, BK_PRE}));

  // R11: the closing phase only ends in idle
  p_pre_to_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BK_PRE) |=> (st inside {BK_PRE, BK_IDLE}));

  // R2: an idle bank stays idle without an activate
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BK_IDLE && !(hit && op == OP_ACT)) |=> (st == BK_IDLE));

  // R3: a write burst is only entered from an open bank
  p_wburst_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == BK_WBURST) |-> ($past(st) == BK_ACTIVE));

  // R6: an interrupted auto-precharge write never reopens
  p_intr_wap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BK_WBURST && intr && apf) |=> (st inside {BK_WREC, BK_PRE}));

endmodule

// File: rtl/sdram_rd_delay.sv
module sdram_rd_delay #(
  parameter int CL = 3,
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic [BW-1:0] in_bank,
  output logic          out_vld,
  output logic [BW-1:0] out_bank
);

  logic [CL-1:0] v_q;
  logic [BW-1:0] b_q [CL];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= '0;
      for (int i = 0; i < CL; i++) b_q[i] <= '0;
    end else begin
      v_q[0] <= in_vld;
      b_q[0] <= in_bank;
      for (int i = 1; i < CL; i++) begin
        v_q[i] <= v_q[i-1];
        b_q[i] <= b_q[i-1];
      end
    end
  end

  assign out_vld  = v_q[CL-1];
  assign out_bank = b_q[CL-1];

  // R7: nothing emerges in the first cycle after reset
  p_no_early_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_vld);

endmodule

// File: rtl/sdram_ap_tracker.sv
module sdram_ap_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BURST_LEN = 4,
  parameter int CAS_LAT   = 3,
  parameter int T_WR      = 2,
  parameter int T_RP      = 3,
  localparam int BW       = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic [2:0]             cmd_code,
  input  logic [BW-1:0]          cmd_bank,
  input  logic                   cmd_ap,
  output logic [3*NUM_BANKS-1:0] bank_state,
  output logic [NUM_BANKS-1:0]   bank_ready,
  output logic                   wr_accept,
  output logic [BW-1:0]          wr_bank,
  output logic                   rd_valid,
  output logic [BW-1:0]          rd_bank,
  output logic                   proto_err
);

  bank_st_e             st [NUM_BANKS];
  logic [NUM_BANKS-1:0] hit;
  logic [NUM_BANKS-1:0] in_burst;
  logic                 rd_now, wr_now, rw_now;
  logic                 any_wb, any_rb;
  logic [BW-1:0]        wb_bank, rb_bank;
  logic                 rd_issue;
  logic [BW-1:0]        rd_iss_bank;

  sdram_cmd_check #(.NB(NUM_BANKS), .BW(BW)) u_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_bank  (cmd_bank),
    .bank_st   (st),
    .hit       (hit),
    .rd_now    (rd_now),
    .wr_now    (wr_now),
    .proto_err (proto_err)
  );

  assign rw_now = rd_now || wr_now;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    sdram_bank_fsm #(.BL(BURST_LEN), .TWR(T_WR), .TRP(T_RP)) u_fsm (
      .clk   (clk),
      .rst_n (rst_n),
      .hit   (hit[g]),
      .op    (cmd_code),
      .ap    (cmd_ap),
      .intr  (rw_now),
      .st    (st[g])
    );
    assign bank_state[3*g +: 3] = st[g];
    assign bank_ready[g]        = (st[g] == BK_IDLE) || (st[g] == BK_ACTIVE);
    assign in_burst[g]          = (st[g] == BK_WBURST) || (st[g] == BK_RBURST);
  end

  // locate the bank that owns the data bus, if any
  always_comb begin
    any_wb  = 1'b0;
    any_rb  = 1'b0;
    wb_bank = '0;
    rb_bank = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (st[i] == BK_WBURST) begin
        any_wb  = 1'b1;
        wb_bank = BW'(i);
      end
      if (st[i] == BK_RBURST) begin
        any_rb  = 1'b1;
        rb_bank = BW'(i);
      end
    end
  end

  // a new read or write takes the bus in its own cycle
  assign wr_accept   = wr_now || (any_wb && !rw_now);
  assign wr_bank     = wr_now ? cmd_bank : wb_bank;
  assign rd_issue    = rd_now || (any_rb && !rw_now);
  assign rd_iss_bank = rd_now ? cmd_bank : rb_bank;

  sdram_rd_delay #(.CL(CAS_LAT), .BW(BW)) u_rd_delay (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (rd_issue),
    .in_bank  (rd_iss_bank),
    .out_vld  (rd_valid),
    .out_bank (rd_bank)
  );

  // R12: one burst owner at a time
  p_one_burst_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_burst));

  // R5: a taken read leaves no write burst running
  p_read_ends_wburst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_now |=> !any_wb);

  // R5: write beats and a read command never share a cycle
  p_no_wr_on_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_now |-> !wr_accept);

endmodule

// File: tb/test_sdram_ap_tracker.sv
module test_sdram_ap_tracker;

  localparam int NB  = 4;
  localparam int BL  = 4;
  localparam int CL  = 3;
  localparam int TWR = 2;
  localparam int TRP = 3;
  localparam int INF = 1 << 30;

  localparam int S_IDLE = 0, S_ACT = 1, S_WB = 2, S_RB = 3, S_WREC = 4, S_PRE = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_code = 3'd0;
  logic [1:0]  cmd_bank = 2'd0;
  logic        cmd_ap = 1'b0;
  logic [11:0] bank_state;
  logic [3:0]  bank_ready;
  logic        wr_accept;
  logic [1:0]  wr_bank;
  logic        rd_valid;
  logic [1:0]  rd_bank;
  logic        proto_err;

  always #5 clk = ~clk;

  sdram_ap_tracker i_sdram_ap_tracker (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .bank_state(bank_state),
    .bank_ready(bank_ready), .wr_accept(wr_accept), .wr_bank(wr_bank),
    .rd_valid(rd_valid), .rd_bank(rd_bank), .proto_err(proto_err)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model: absolute-time deadlines per bank
  int mst [NB];
  int mend[NB];
  bit map [NB];
  bit merr = 0;
  int cyc = 0;
  int q_due[$];
  int q_iss[$];
  int q_bank[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
    end
  endtask

  task automatic advance(input int c);
    for (int b = 0; b < NB; b++) begin
      while (mend[b] <= c) begin
        case (mst[b])
          S_WB:   if (map[b]) begin mst[b] = S_WREC; mend[b] += TWR; end
                  else begin mst[b] = S_ACT; mend[b] = INF; end
          S_WREC: begin mst[b] = S_PRE; mend[b] += TRP; end
          S_RB:   if (map[b]) begin mst[b] = S_PRE; mend[b] += TRP; end
                  else begin mst[b] = S_ACT; mend[b] = INF; end
          S_PRE:  begin mst[b] = S_IDLE; mend[b] = INF; end
          default: mend[b] = INF;
        endcase
      end
    end
  endtask

  function automatic bit is_legal(input bit v, input int code, input int bank);
    if (!v) return 1;
    case (code)
      0: return 1;
      1: return mst[bank] == S_IDLE;
      2, 3: return mst[bank] == S_ACT;
      4: return mst[bank] == S_IDLE || mst[bank] == S_ACT;
      default: return 0;
    endcase
  endfunction

  task automatic apply(input int c, input bit v, input int code, input int bank, input bit ap);
    if (!v) return;
    if (!is_legal(v, code, bank)) begin merr = 1; return; end
    case (code)
      1: begin mst[bank] = S_ACT; mend[bank] = INF; end
      4: if (mst[bank] == S_ACT) begin mst[bank] = S_PRE; mend[bank] = c + 1 + TRP; end
      2, 3: begin
        for (int b = 0; b < NB; b++) begin
          if (mst[b] == S_WB) begin
            if (map[b]) begin mst[b] = S_WREC; mend[b] = c + TWR; end
            else begin mst[b] = S_ACT; mend[b] = INF; end
          end else if (mst[b] == S_RB) begin
            if (map[b]) begin mst[b] = S_PRE; mend[b] = c + 1 + TRP; end
            else begin mst[b] = S_ACT; mend[b] = INF; end
          end
        end
        for (int k = q_iss.size() - 1; k >= 0; k--) begin
          if (q_iss[k] >= c) begin
            q_iss.delete(k); q_due.delete(k); q_bank.delete(k);
          end
        end
        mst[bank] = (code == 3) ? S_WB : S_RB;
        mend[bank] = c + BL;
        map[bank] = ap;
        if (code == 2) begin
          for (int k = 0; k < BL; k++) begin
            q_due.push_back(c + CL + k); q_iss.push_back(c + k); q_bank.push_back(bank);
          end
        end
      end
      default: ;
    endcase
  endtask

  task automatic step(input bit v, input int code, input int bank, input bit ap);
    bit lg, exp_wr, exp_rd;
    int exp_wb, exp_rb;
    @(negedge clk);
    cmd_valid = v; cmd_code = 3'(code); cmd_bank = 2'(bank); cmd_ap = ap;
    #1;
    advance(cyc);
    lg = is_legal(v, code, bank) && v;
    exp_wr = 0; exp_wb = 0;
    if (lg && code == 3) begin exp_wr = 1; exp_wb = bank; end
    else if (!(lg && code == 2)) begin
      for (int b = 0; b < NB; b++) if (mst[b] == S_WB) begin exp_wr = 1; exp_wb = b; end
    end
    exp_rd = 0; exp_rb = 0;
    for (int k = q_due.size() - 1; k >= 0; k--) begin
      if (q_due[k] == cyc) begin
        exp_rd = 1; exp_rb = q_bank[k];
        q_due.delete(k); q_iss.delete(k); q_bank.delete(k);
      end
    end
    for (int b = 0; b < NB; b++) begin
      chk(int'(bank_state[3*b +: 3]) == mst[b], "R2/R3/R4/R6/R8/R11/R12", "bank_state",
          int'(bank_state[3*b +: 3]), mst[b]);
      chk(bank_ready[b] == (mst[b] == S_IDLE || mst[b] == S_ACT), "R9", "bank_ready",
          int'(bank_ready[b]), int'(mst[b] == S_IDLE || mst[b] == S_ACT));
    end
    chk(wr_accept == exp_wr, "R3/R5", "wr_accept", int'(wr_accept), int'(exp_wr));
    if (exp_wr) chk(int'(wr_bank) == exp_wb, "R3/R5", "wr_bank", int'(wr_bank), exp_wb);
    chk(rd_valid == exp_rd, "R7", "rd_valid", int'(rd_valid), int'(exp_rd));
    if (exp_rd) chk(int'(rd_bank) == exp_rb, "R7", "rd_bank", int'(rd_bank), exp_rb);
    chk(proto_err == merr, "R10", "proto_err", int'(proto_err), int'(merr));
    apply(cyc, v, code, bank, ap);
    cyc++;
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 0, 1'b0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d: actual 0 expected 1", cyc);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    int code;
    for (int b = 0; b < NB; b++) begin mst[b] = S_IDLE; mend[b] = INF; map[b] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(bank_state == 12'd0, "R1", "bank_state", int'(bank_state), 0);
    chk(bank_ready == 4'hF, "R1", "bank_ready", int'(bank_ready), 15);
    chk(!wr_accept && !rd_valid, "R1", "strobes", int'({wr_accept, rd_valid}), 0);
    chk(!proto_err, "R1", "proto_err", int'(proto_err), 0);

    // R6/R7: write with auto-precharge cut short by a read with auto-precharge
    step(1, 1, 0, 0); step(1, 1, 1, 0); nop(1);
    step(1, 3, 0, 1); nop(1);
    step(1, 2, 1, 1); nop(14);
    // R3/R4: plain write then uninterrupted auto-precharge write
    step(1, 1, 2, 0); step(1, 3, 2, 0); nop(5);
    step(1, 3, 2, 1); nop(12);
    // R12: plain read cut by an auto-precharge write, which a read then cuts
    step(1, 1, 3, 0); step(1, 1, 0, 0);
    step(1, 2, 3, 0); nop(1);
    step(1, 3, 0, 1); nop(2);
    step(1, 2, 3, 1); nop(14);
    // R11: precharge to idle and to open banks
    step(1, 4, 3, 0); step(1, 1, 1, 0); step(1, 4, 1, 0); nop(5);
    // R10: illegal commands
    step(1, 2, 2, 0); nop(1);
    step(1, 1, 0, 0); step(1, 1, 0, 0); step(1, 6, 0, 0); nop(3);
    // mixed traffic
    lfsr = 32'h1ACE_B00C;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (lfsr[3:0])
        4'd0, 4'd1, 4'd2, 4'd3: code = 0;
        4'd4, 4'd5, 4'd6:       code = 1;
        4'd7, 4'd8, 4'd9:       code = 2;
        4'd10, 4'd11, 4'd12:    code = 3;
        4'd13, 4'd14:           code = 4;
        default:                code = 7;
      endcase
      step(lfsr[7] | lfsr[8], code, int'(lfsr[6:5]), lfsr[4]);
    end
    nop(20);
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule